// File: doc/BRIEF.md
# Queue Pointer Controller

This block keeps a bank of hardware ring queues, each one a pair of free-running pointers plus a ring-size setting and a few sticky error flags. A host on a simple 32-bit register bus moves a pointer only by posting a small increment to a dedicated add register in that queue's address window. It never writes a pointer value directly. It reads each pointer back from its own status word, where the flags sit in the top two bits.

The fill level of a queue is the write pointer minus the read pointer, modulo 2^18. The block refuses any add that would make the fill level exceed the ring size, and any add that would move the read pointer past the write pointer. It also refuses an increment above 63. A refused add leaves the pointer where it was and raises a sticky flag, which the host clears by writing a 1 into that flag's bit. The entry index of each pointer, wrapped at the ring size, can also be read back.

Top module: `qpc_top`

## Requirements
- R1: While rst_n is low at a clock edge, every pointer and flag of every queue becomes zero and every size code becomes 8 (a ring of 256 entries).
- R2: The queue bank answers only when bus_addr[19] is 1. Bits [18:11] give the queue number, and bits [10:2] select the word in that queue's 0x800-byte window. An access to a queue number at or above NUM_Q, or with bus_addr[19] low, changes no queue and reads as zero. It does not alias onto another queue.
- R3: A write of v to word offset 0x0 adds v to the queue's read pointer.
- R4: A write of v to word offset 0x4 adds v to the queue's write pointer. No pointer changes without a write aimed at it.
- R5: A read of offset 0x8 returns the read pointer in bits [17:0], and a read of offset 0xC returns the write pointer in bits [17:0]. bus_rdata carries the value on the clock edge that follows the edge sampling bus_rd, and a write shows in reads issued after its edge.
- R6: An add write whose 32-bit value is above 63 leaves the pointer unchanged. It sets the sticky error flag, bit 30, of that pointer's status word (0x8 for the read pointer, 0xC for the write pointer).
- R7: A write-pointer add that would make the fill level exceed 2^code entries is refused. The write pointer holds and bit 31 of word 0xC (overflow) is set.
- R8: A read-pointer add larger than the current fill level is refused. The read pointer holds and bit 31 of word 0x8 (underflow) is set.
- R9: A write to 0x8 or 0xC clears each flag of that word whose bit is 1 in the data and leaves flags with a 0 bit set. Status bits [29:18] read as zero.
- R10: A write to 0x10 sets the size code from data bits [31:0], clamped to 8..18. A read of 0x10 returns the code in bits [4:0].
- R11: A read of 0x14 returns the read pointer masked by 2^code-1, and a read of 0x18 returns the write pointer masked the same way.
- R12: Pointers are 18 bits wide and wrap modulo 2^18. The fill level is computed across that wrap.
- R13: Operations on one queue leave every other queue's pointers and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 20 | Byte address: bank bit, queue number, word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench drives the ring exactly to the fill boundary. An add reaching precisely 256 entries must pass, and one entry more must be refused. A design with an off-by-one in the fill compare would either reject a legal add or let the ring overfill. Increments of 64 and 256 probe the add limit; a design that truncated the value instead of rejecting it would move the pointer by 0 or by a wrapped amount. The clear tests write the wrong bit and a zero word, which a design clearing on any write would get wrong. Addresses with the bank bit low, or with queue numbers beyond the bank, must not alias onto a real queue. A long run of paired adds carries both pointers past 2^18, where a design with a wider pointer or a fill level computed without the modulus would report a spurious overflow or a wrong pointer.

// File: rtl/qpc_pkg.sv
// Shared definitions for the queue pointer controller: decoded operations,
// read selections and the bit positions of the sticky flags in status words.
package qpc_pkg;

    // Bit positions of the sticky flags inside a status word
    localparam int ERR_BIT  = 30;
    localparam int FLOW_BIT = 31;

    // Write-side operation presented to one queue
    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADD_RD,
        OP_ADD_WR,
        OP_CLR_RD,
        OP_CLR_WR,
        OP_SIZE
    } op_e;

    // Read-side word selection
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STS_RD,
        SEL_STS_WR,
        SEL_SIZE,
        SEL_IDX_RD,
        SEL_IDX_WR
    } sel_e;

    // Sticky flags attached to one pointer
    typedef struct packed {
        logic flow;
        logic err;
    } flags_t;

endpackage

// File: rtl/qpc_decode.sv
// Address decoder. Splits a bus address into bank hit, queue number and word
// offset, and turns a strobe into a write operation or a read selection.
// Assumes a word-aligned bus; address bits [1:0] are ignored. Queue numbers
// at or beyond NUM_Q miss, so they never alias onto a real queue.
module qpc_decode
    import qpc_pkg::*;
#(
    parameter int NUM_Q    = 4,
    parameter int QSEL_W   = 8,
    parameter int WIN_BITS = 11,
    parameter int QIDX_W   = 2
) (
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [WIN_BITS+QSEL_W:0]   addr,
    output op_e                        wr_op,
    output sel_e                       rd_sel,
    output logic [QIDX_W-1:0]          qidx
);
    localparam int WORD_W = WIN_BITS - 2;

    logic              bank_hit;
    logic [QSEL_W-1:0] qnum;
    logic              q_ok;
    logic [WORD_W-1:0] word;

    // Split the address into its fields
    always_comb begin
        bank_hit = addr[WIN_BITS+QSEL_W];
        qnum     = addr[WIN_BITS +: QSEL_W];
        word     = addr[WIN_BITS-1:2];
        q_ok     = bank_hit && (int'(qnum) < NUM_Q);
        qidx     = qnum[QIDX_W-1:0];
    end

    // Map a write strobe and word offset onto an operation
    always_comb begin
        wr_op = OP_NONE;
        if (wr_en && q_ok) begin
            case (int'(word))
                0:       wr_op = OP_ADD_RD;
                1:       wr_op = OP_ADD_WR;
                2:       wr_op = OP_CLR_RD;
                3:       wr_op = OP_CLR_WR;
                4:       wr_op = OP_SIZE;
                default: wr_op = OP_NONE;
            endcase
        end
    end

    // Map a read strobe and word offset onto a word selection
    always_comb begin
        rd_sel = SEL_NONE;
        if (rd_en && q_ok) begin
            case (int'(word))
                2:       rd_sel = SEL_STS_RD;
                3:       rd_sel = SEL_STS_WR;
                4:       rd_sel = SEL_SIZE;
                5:       rd_sel = SEL_IDX_RD;
                6:       rd_sel = SEL_IDX_WR;
                default: rd_sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/qpc_queue.sv
// State of one ring queue: two free-running pointers, a size code and the
// sticky flags. Applies one operation per cycle. Adds above ADD_MAX, adds
// that would overfill the ring and adds that would pass the write pointer are
// refused and flagged. Assumes PTR_W <= 30 and SZ_MAX <= PTR_W.
module qpc_queue
    import qpc_pkg::*;
#(
    parameter int PTR_W   = 18,
    parameter int ADD_MAX = 63,
    parameter int SZ_MIN  = 8,
    parameter int SZ_MAX  = 18,
    parameter int SZC_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic [31:0]      wdata,
    output logic [PTR_W-1:0] rptr,
    output logic [PTR_W-1:0] wptr,
    output logic [SZC_W-1:0] szc,
    output flags_t           rflags,
    output flags_t           wflags,
    output logic [PTR_W-1:0] ridx,
    output logic [PTR_W-1:0] widx
);
    logic [PTR_W-1:0] fill;
    logic [PTR_W-1:0] inc;
    logic [PTR_W:0]   size_ext;
    logic [PTR_W:0]   new_fill;
    logic [PTR_W-1:0] mask;
    logic             too_big;
    logic             would_ovf;
    logic             would_unf;
    logic [SZC_W-1:0] szc_next;

    // Fill level, limits and wrapped indices
    always_comb begin
        fill      = wptr - rptr;
        inc       = wdata[PTR_W-1:0];
        too_big   = wdata > 32'(ADD_MAX);
        size_ext  = {{PTR_W{1'b0}}, 1'b1} << szc;
        new_fill  = {1'b0, fill} + {1'b0, inc};
        would_ovf = new_fill > size_ext;
        would_unf = inc > fill;
        mask      = size_ext[PTR_W-1:0] - {{(PTR_W-1){1'b0}}, 1'b1};
        ridx      = rptr & mask;
        widx      = wptr & mask;
    end

    // Clamp a written size code into the legal range
    always_comb begin
        if (wdata < 32'(SZ_MIN))      szc_next = SZC_W'(SZ_MIN);
        else if (wdata > 32'(SZ_MAX)) szc_next = SZC_W'(SZ_MAX);
        else                          szc_next = wdata[SZC_W-1:0];
    end

    // Apply the operation to pointers, flags and size
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr   <= '0;
            wptr   <= '0;
            rflags <= '0;
            wflags <= '0;
            szc    <= SZC_W'(SZ_MIN);
        end else begin
            case (op)
                OP_ADD_RD: begin
                    if (too_big)        rflags.err  <= 1'b1;
                    else if (would_unf) rflags.flow <= 1'b1;
                    else                rptr        <= rptr + inc;
                end
                OP_ADD_WR: begin
                    if (too_big)        wflags.err  <= 1'b1;
                    else if (would_ovf) wflags.flow <= 1'b1;
                    else                wptr        <= wptr + inc;
                end
                OP_CLR_RD: begin
                    if (wdata[ERR_BIT])  rflags.err  <= 1'b0;
                    if (wdata[FLOW_BIT]) rflags.flow <= 1'b0;
                end
                OP_CLR_WR: begin
                    if (wdata[ERR_BIT])  wflags.err  <= 1'b0;
                    if (wdata[FLOW_BIT]) wflags.flow <= 1'b0;
                end
                OP_SIZE:  szc <= szc_next;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/qpc_rdport.sv
// Read port. Forms the selected word from one queue's state and registers it,
// giving one cycle of read latency. Misses read as zero; with no read strobe
// the last value is held.
module qpc_rdport
    import qpc_pkg::*;
#(
    parameter int PTR_W = 18,
    parameter int SZC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  sel_e             sel,
    input  logic [PTR_W-1:0] rptr,
    input  logic [PTR_W-1:0] wptr,
    input  logic [SZC_W-1:0] szc,
    input  flags_t           rflags,
    input  flags_t           wflags,
    input  logic [PTR_W-1:0] ridx,
    input  logic [PTR_W-1:0] widx,
    output logic [31:0]      rdata
);
    localparam int PAD_W = ERR_BIT - PTR_W;

    logic [31:0] word;

    // Build the selected word
    always_comb begin
        case (sel)
            SEL_STS_RD: word = {rflags.flow, rflags.err, {PAD_W{1'b0}}, rptr};
            SEL_STS_WR: word = {wflags.flow, wflags.err, {PAD_W{1'b0}}, wptr};
            SEL_SIZE:   word = {{(32-SZC_W){1'b0}}, szc};
            SEL_IDX_RD: word = {{(32-PTR_W){1'b0}}, ridx};
            SEL_IDX_WR: word = {{(32-PTR_W){1'b0}}, widx};
            default:    word = '0;
        endcase
    end

    // Register the word on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= word;
    end

endmodule

// File: rtl/qpc_top.sv
// Queue pointer controller top. Decodes bus accesses, steers each write
// operation to one queue of the bank and returns registered read data. The
// bank occupies the upper half of the address space, one window per queue.
module qpc_top
    import qpc_pkg::*;
#(
    parameter int NUM_Q    = 4,
    parameter int PTR_W    = 18,
    parameter int QSEL_W   = 8,
    parameter int WIN_BITS = 11,
    parameter int ADD_MAX  = 63,
    parameter int SZ_MIN   = 8,
    parameter int SZ_MAX   = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [WIN_BITS+QSEL_W:0] bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata
);
    localparam int QIDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
    localparam int SZC_W  = $clog2(SZ_MAX + 1);

    op_e               wr_op;
    sel_e              rd_sel;
    logic [QIDX_W-1:0] qidx;

    logic [PTR_W-1:0] rptr_q [NUM_Q];
    logic [PTR_W-1:0] wptr_q [NUM_Q];
    logic [SZC_W-1:0] szc_q  [NUM_Q];
    flags_t           rfl_q  [NUM_Q];
    flags_t           wfl_q  [NUM_Q];
    logic [PTR_W-1:0] ridx_q [NUM_Q];
    logic [PTR_W-1:0] widx_q [NUM_Q];

    qpc_decode #(
        .NUM_Q(NUM_Q), .QSEL_W(QSEL_W), .WIN_BITS(WIN_BITS), .QIDX_W(QIDX_W)
    ) decode_i (
        .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
        .wr_op(wr_op), .rd_sel(rd_sel), .qidx(qidx)
    );

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_queue
        op_e q_op;

        // Pass the operation only to the addressed queue
        always_comb q_op = (int'(qidx) == gi) ? wr_op : OP_NONE;

        qpc_queue #(
            .PTR_W(PTR_W), .ADD_MAX(ADD_MAX), .SZ_MIN(SZ_MIN),
            .SZ_MAX(SZ_MAX), .SZC_W(SZC_W)
        ) queue_i (
            .clk(clk), .rst_n(rst_n), .op(q_op), .wdata(bus_wdata),
            .rptr(rptr_q[gi]), .wptr(wptr_q[gi]), .szc(szc_q[gi]),
            .rflags(rfl_q[gi]), .wflags(wfl_q[gi]),
            .ridx(ridx_q[gi]), .widx(widx_q[gi])
        );
    end

    qpc_rdport #(
        .PTR_W(PTR_W), .SZC_W(SZC_W)
    ) rdport_i (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .sel(rd_sel),
        .rptr(rptr_q[qidx]), .wptr(wptr_q[qidx]), .szc(szc_q[qidx]),
        .rflags(rfl_q[qidx]), .wflags(wfl_q[qidx]),
        .ridx(ridx_q[qidx]), .widx(widx_q[qidx]),
        .rdata(bus_rdata)
    );

endmodule

// File: rtl/qpc_chk.sv
// Assertion checker for the queue pointer controller, bound to the top.
// Watches queue 0's pointers and write-side overflow flag together with the bus.
module qpc_chk #(
    parameter int WIN_BITS = 11,
    parameter int QSEL_W   = 8,
    parameter int PTR_W    = 18,
    parameter int ADD_MAX  = 63
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [WIN_BITS+QSEL_W:0] bus_addr,
    input logic [31:0]              bus_wdata,
    input logic [31:0]              bus_rdata,
    input logic [PTR_W-1:0]         rptr0,
    input logic [PTR_W-1:0]         wptr0,
    input logic                     wovf0
);
    localparam int MSB = WIN_BITS + QSEL_W;

    logic q0_hit;
    // Access aimed at queue 0's window
    always_comb q0_hit = bus_addr[MSB] && (bus_addr[WIN_BITS +: QSEL_W] == '0);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rptr0 == '0) && (wptr0 == '0));

    // R2
    miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr[MSB]) |=> (bus_rdata == 32'd0));

    // R4
    wptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(wptr0));

    // R6
    big_add_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && q0_hit && (bus_addr[WIN_BITS-1:2] == '0) && (bus_wdata > 32'(ADD_MAX)))
        |=> $stable(rptr0));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wovf0 && !(bus_wr && q0_hit && (int'(bus_addr[WIN_BITS-1:2]) == 3) && bus_wdata[31]))
        |=> wovf0);

endmodule

bind qpc_top qpc_chk #(
    .WIN_BITS(WIN_BITS), .QSEL_W(QSEL_W), .PTR_W(PTR_W), .ADD_MAX(ADD_MAX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rptr0(rptr_q[0]), .wptr0(wptr_q[0]), .wovf0(wfl_q[0].flow)
);

// File: tb/qpc_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the queue pointer controller: one task per scenario.
module qpc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    qpc_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [19:0] qa(int q, int off);
        return 20'h80000 | 20'(q << 11) | 20'(off);
    endfunction

    task automatic wr(logic [19:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic rd_check(string req, logic [19:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        rd_check("R1 rptr after reset", qa(0, 8), 0);
        rd_check("R1 wptr after reset", qa(0, 12), 0);
        rd_check("R1 size code after reset", qa(3, 16), 8);
    endtask

    task automatic t_basic();
        wr(qa(1, 4), 10);
        wr(qa(1, 0), 4);
        rd_check("R4 wptr add", qa(1, 12), 10);
        rd_check("R3 R5 rptr add", qa(1, 8), 4);
        rd_check("R13 other queue wptr", qa(2, 12), 0);
        rd_check("R13 other queue rptr", qa(0, 8), 0);
    endtask

    task automatic t_decode();
        wr(20'h00800 | 20'd4, 7);
        rd_check("R2 bank bit low ignored", qa(1, 12), 10);
        wr(qa(4, 4), 9);
        rd_check("R2 queue 4 no alias to 0", qa(0, 12), 0);
        wr(qa(5, 4), 9);
        rd_check("R2 missing queue reads 0", qa(5, 12), 0);
        rd_check("R2 bank bit low reads 0", 20'h00800 | 20'd12, 0);
    endtask

    task automatic t_too_big();
        wr(qa(0, 4), 32'h40);
        rd_check("R6 wr add 64 refused", qa(0, 12), 32'h4000_0000);
        wr(qa(0, 0), 32'h100);
        rd_check("R6 rd add 256 refused", qa(0, 8), 32'h4000_0000);
    endtask

    task automatic t_clear();
        wr(qa(0, 12), 0);
        rd_check("R9 zero word keeps flag", qa(0, 12), 32'h4000_0000);
        wr(qa(0, 12), 32'h4000_0000);
        rd_check("R9 clear wr err", qa(0, 12), 0);
        wr(qa(0, 8), 32'h8000_0000);
        rd_check("R9 wrong bit keeps flag", qa(0, 8), 32'h4000_0000);
        wr(qa(0, 8), 32'h4000_0000);
        rd_check("R9 clear rd err", qa(0, 8), 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 4; i++) wr(qa(3, 4), 63);
        wr(qa(3, 4), 5);
        rd_check("R7 overfill refused", qa(3, 12), 32'h8000_00FC);
        wr(qa(3, 4), 4);
        rd_check("R7 exact fill accepted", qa(3, 12), 32'h8000_0100);
    endtask

    task automatic t_underflow();
        for (int i = 0; i < 4; i++) wr(qa(3, 0), 63);
        wr(qa(3, 0), 5);
        rd_check("R8 pass wptr refused", qa(3, 8), 32'h8000_00FC);
        wr(qa(3, 0), 4);
        rd_check("R8 drain to empty", qa(3, 8), 32'h8000_0100);
    endtask

    task automatic t_size();
        wr(qa(1, 16), 3);
        rd_check("R10 clamp low", qa(1, 16), 8);
        wr(qa(1, 16), 25);
        rd_check("R10 clamp high", qa(1, 16), 18);
        wr(qa(1, 16), 10);
        rd_check("R10 legal code", qa(1, 16), 10);
    endtask

    task automatic t_index();
        for (int i = 0; i < 4; i++) wr(qa(2, 4), 63);
        for (int i = 0; i < 4; i++) wr(qa(2, 0), 63);
        wr(qa(2, 4), 48);
        rd_check("R11 wr index wraps at 256", qa(2, 24), 44);
        rd_check("R11 rd index", qa(2, 20), 252);
        wr(qa(2, 16), 9);
        rd_check("R11 wr index at 512", qa(2, 24), 300);
    endtask

    task automatic t_wrap();
        wr(qa(0, 16), 18);
        for (int i = 0; i < 4200; i++) begin
            wr(qa(0, 4), 63);
            wr(qa(0, 0), 63);
        end
        rd_check("R12 wptr wraps mod 2^18", qa(0, 12), 2456);
        rd_check("R12 rptr wraps mod 2^18", qa(0, 8), 2456);
        rd_check("R12 index at largest ring", qa(0, 24), 2456);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_decode();
        t_too_big();
        t_clear();
        t_overflow();
        t_underflow();
        t_size();
        t_index();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule